// File: doc/BRIEF.md
# Slotted Two-Input Contention Resolver

This block merges two time-slotted packet streams onto one shared output. Every packet is a fixed number of words long. Both inputs are aligned to a common slot grid: a start strobe marks the first word of each slot, and each input raises its own presence flag in that cycle. A single-packet recirculating store, built as a delay line exactly one slot long, absorbs one losing packet when both inputs arrive together. The stored packet goes back onto the output in the next slot that has no arrivals.

The steering for a slot comes from a half adder on the two presence flags. The carry marks contention. The sum marks a single arrival. When neither is set, the slot is empty. The decision is captured on the start strobe and held for every word of the slot. Input "hi" always wins over input "lo". On contention, the lo packet overwrites whatever the store held. A one-cycle drop pulse reports that a stored packet was discarded.

Top module: `slot_contention_resolver`

## Requirements
- R1: While reset is high, and in the cycle after it, out_valid and drop_pulse are 0, and the store is marked empty.
- R2: In a slot where only lo_present is set, the lo packet words appear on out_word with out_valid = 1. The stored packet, if any, stays in the store unchanged.
- R3: In a slot where only hi_present is set, the hi packet words appear on out_word with out_valid = 1. The stored packet, if any, stays in the store unchanged.
- R4: In a slot where both presence flags are set, the hi packet is forwarded and the lo packet becomes the new content of the store.
- R5: When a contention slot finds the store holding a packet, that packet is lost for good, and drop_pulse is 1 in the cycle that carries the first output word of the slot.
- R6: In a slot with neither presence flag set, a stored packet is sent to the output word by word, and afterwards the store is empty.
- R7: An empty slot that finds the store empty produces out_valid = 0 for all of its words.
- R8: Presence flags are sampled only in the cycle where slot_start is 1. Changes to them in the other words of the slot have no effect on output or store.
- R9: Each output word appears exactly one cycle after the matching input word was presented. The words of a packet leave in the order they arrived.
- R10: drop_pulse is never high for two cycles in a row. It is high only in a cycle whose preceding cycle had slot_start = 1 with both presence flags set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| slot_start | input | 1 | High on the first word of every slot. Slots are contiguous, SLOT_WORDS cycles apart |
| lo_present | input | 1 | Low-priority input holds a packet this slot (sampled on slot_start) |
| lo_word | input | DATA_W | Low-priority packet word |
| hi_present | input | 1 | High-priority input holds a packet this slot (sampled on slot_start) |
| hi_word | input | DATA_W | High-priority packet word |
| out_valid | output | 1 | out_word carries a packet word |
| out_word | output | DATA_W | Forwarded packet word |
| drop_pulse | output | 1 | One-cycle pulse when a stored packet is discarded |

## Verification
The bench runs every sequence of three slot types back to back, then a long random run. The store therefore meets every neighbour combination, including contention followed by a single arrival and then an empty slot. A wrong store length would release words from the wrong slot, or rotate words within a packet. Such errors show up because each word encodes both its packet and its position. Presence flags are flipped in the middle of every slot: a design that decoded them on every cycle would switch sources partway through a packet. The drop pulse is checked against a reference record of store occupancy. This catches a design that pulses on an empty store, or one that keeps the old packet instead of the lo packet.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // Per-slot steering decision derived from the two presence flags
    typedef struct packed {
        logic insert;       // lower-priority packet goes into the store
        logic discard;      // current store content is thrown away
        logic recirc;       // store content loops back into the store
        logic release_buf;  // store content goes to the output
        logic take_hi;      // forwarded input is the high-priority one
    } steer_t;

    localparam steer_t STEER_IDLE = '{insert: 1'b0, discard: 1'b0, recirc: 1'b0,
                                      release_buf: 1'b1, take_hi: 1'b0};

    // Half adder: carry = contention, sum = single arrival
    function automatic steer_t steer_from_flags(input logic lo_p, input logic hi_p);
        steer_t s;
        logic carry_c;
        logic sum_c;
        carry_c       = lo_p & hi_p;
        sum_c         = lo_p ^ hi_p;
        s.insert      = carry_c;
        s.discard     = carry_c;
        s.recirc      = sum_c;
        s.release_buf = ~(carry_c | sum_c);
        s.take_hi     = hi_p;
        return s;
    endfunction

endpackage

// File: rtl/rsv_slot_ctrl.sv
module rsv_slot_ctrl
    import rsv_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   slot_start,
    input  logic   lo_p,
    input  logic   hi_p,
    output steer_t steer,
    output logic   first_word
);
    steer_t live_s;
    steer_t held_q;

    assign live_s = steer_from_flags(lo_p, hi_p);

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= STEER_IDLE;
        end else if (slot_start) begin
            held_q <= live_s;
        end
    end

    // First word uses the live decision, the rest of the slot the held one
    assign steer      = slot_start ? live_s : held_q;
    assign first_word = slot_start;
endmodule

// File: rtl/rsv_delay_line.sv
module rsv_delay_line #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);
    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] v_q;
    logic [W-1:0]     d_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q <= '0;
        end else begin
            v_q[0] <= in_v;
            for (int i = 1; i < DEPTH; i++) begin
                v_q[i] <= v_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        d_q[0] <= in_d;
        for (int i = 1; i < DEPTH; i++) begin
            d_q[i] <= d_q[i-1];
        end
    end

    assign out_v = v_q[LAST];
    assign out_d = d_q[LAST];
endmodule

// File: rtl/rsv_steer.sv
module rsv_steer
    import rsv_pkg::*;
#(
    parameter int W = 8
) (
    input  steer_t       steer,
    input  logic         first_word,
    input  logic [W-1:0] lo_word,
    input  logic [W-1:0] hi_word,
    input  logic         head_v,
    input  logic [W-1:0] head_d,
    output logic         fwd_v,
    output logic [W-1:0] fwd_d,
    output logic         store_v,
    output logic [W-1:0] store_d,
    output logic         drop_now
);
    always_comb begin
        // Output side
        if (steer.release_buf) begin
            fwd_v = head_v;
            fwd_d = head_d;
        end else begin
            fwd_v = 1'b1;
            fwd_d = steer.take_hi ? hi_word : lo_word;
        end
        // Store side
        if (steer.insert) begin
            store_v = 1'b1;
            store_d = lo_word;
        end else if (steer.recirc) begin
            store_v = head_v;
            store_d = head_d;
        end else begin
            store_v = 1'b0;
            store_d = head_d;
        end
        drop_now = steer.discard & first_word & head_v;
    end
endmodule

// File: rtl/slot_contention_resolver.sv
module slot_contention_resolver
    import rsv_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int SLOT_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot_start,
    input  logic              lo_present,
    input  logic [DATA_W-1:0] lo_word,
    input  logic              hi_present,
    input  logic [DATA_W-1:0] hi_word,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_word,
    output logic              drop_pulse
);
    steer_t            steer;
    logic              first_word;
    logic              head_v;
    logic [DATA_W-1:0] head_d;
    logic              fwd_v;
    logic [DATA_W-1:0] fwd_d;
    logic              store_v;
    logic [DATA_W-1:0] store_d;
    logic              drop_now;

    rsv_slot_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .slot_start (slot_start),
        .lo_p       (lo_present),
        .hi_p       (hi_present),
        .steer      (steer),
        .first_word (first_word)
    );

    rsv_delay_line #(.W(DATA_W), .DEPTH(SLOT_WORDS)) u_store (
        .clk   (clk),
        .rst   (rst),
        .in_v  (store_v),
        .in_d  (store_d),
        .out_v (head_v),
        .out_d (head_d)
    );

    rsv_steer #(.W(DATA_W)) u_steer (
        .steer      (steer),
        .first_word (first_word),
        .lo_word    (lo_word),
        .hi_word    (hi_word),
        .head_v     (head_v),
        .head_d     (head_d),
        .fwd_v      (fwd_v),
        .fwd_d      (fwd_d),
        .store_v    (store_v),
        .store_d    (store_d),
        .drop_now   (drop_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            drop_pulse <= 1'b0;
        end else begin
            out_valid  <= fwd_v;
            drop_pulse <= drop_now;
        end
    end

    always_ff @(posedge clk) begin
        out_word <= fwd_d;
    end
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              slot_start,
    input logic              lo_present,
    input logic [DATA_W-1:0] lo_word,
    input logic              hi_present,
    input logic [DATA_W-1:0] hi_word,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_word,
    input logic              drop_pulse
);
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!out_valid && !drop_pulse));

    p_single_forward_r2: assert property (@(posedge clk) disable iff (rst)
        (slot_start && (lo_present ^ hi_present)) |=>
            (out_valid && out_word == $past(hi_present ? hi_word : lo_word)));

    p_contend_hi_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (slot_start && lo_present && hi_present) |=>
            (out_valid && out_word == $past(hi_word)));

    p_drop_single_cycle_r10: assert property (@(posedge clk) disable iff (rst)
        drop_pulse |=> !drop_pulse);

    p_drop_on_contention_r5: assert property (@(posedge clk) disable iff (rst)
        drop_pulse |-> $past(slot_start && lo_present && hi_present));
endmodule

bind slot_contention_resolver rsv_checker #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .slot_start (slot_start),
    .lo_present (lo_present),
    .lo_word    (lo_word),
    .hi_present (hi_present),
    .hi_word    (hi_word),
    .out_valid  (out_valid),
    .out_word   (out_word),
    .drop_pulse (drop_pulse)
);

// File: tb/slot_contention_resolver_test.sv
module slot_contention_resolver_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int NW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          slot_start = 1'b0;
    logic          lo_present = 1'b0;
    logic [DW-1:0] lo_word = '0;
    logic          hi_present = 1'b0;
    logic [DW-1:0] hi_word = '0;
    logic          out_valid;
    logic [DW-1:0] out_word;
    logic          drop_pulse;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference store record
    bit     ref_full = 1'b0;
    int     ref_id   = 0;
    int     next_id  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_contention_resolver #(.DATA_W(DW), .SLOT_WORDS(NW)) uut (
        .clk        (clk),
        .rst        (rst),
        .slot_start (slot_start),
        .lo_present (lo_present),
        .lo_word    (lo_word),
        .hi_present (hi_present),
        .hi_word    (hi_word),
        .out_valid  (out_valid),
        .out_word   (out_word),
        .drop_pulse (drop_pulse)
    );

    function automatic logic [DW-1:0] word_of(input int id, input int w);
        return DW'((id % 64) * NW + w);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // One slot: presence flags on the first word, inverted afterwards (R8)
    task automatic run_slot(input bit lp, input bit hp);
        int  lid = next_id;
        int  hid = next_id + 1;
        bit  exp_v;
        int  exp_id;
        string req;
        next_id += 2;
        if (lp && hp) begin
            exp_v = 1'b1; exp_id = hid; req = "R4";
        end else if (lp) begin
            exp_v = 1'b1; exp_id = lid; req = "R2";
        end else if (hp) begin
            exp_v = 1'b1; exp_id = hid; req = "R3";
        end else begin
            exp_v = ref_full; exp_id = ref_id;
            req = ref_full ? "R6" : "R7";
        end
        for (int w = 0; w < NW; w++) begin
            slot_start = (w == 0);
            lo_present = (w == 0) ? lp : !lp;
            hi_present = (w == 0) ? hp : !hp;
            lo_word    = word_of(lid, w);
            hi_word    = word_of(hid, w);
            @(posedge clk);
            #1;
            // R9: word w of this slot one cycle after it was presented
            check({req, "/R8 valid"}, int'(out_valid), int'(exp_v));
            if (exp_v) check({req, "/R9 word"}, int'(out_word), int'(word_of(exp_id, w)));
            check("R5/R10 drop", int'(drop_pulse),
                  int'((w == 0) && lp && hp && ref_full));
        end
        slot_start = 1'b0;
        if (lp && hp) begin
            ref_full = 1'b1; ref_id = lid;
        end else if (!lp && !hp) begin
            ref_full = 1'b0;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 valid in reset", int'(out_valid), 0);
        check("R1 drop in reset", int'(drop_pulse), 0);
        rst = 1'b0;
        // R1/R7: first empty slot after reset shows nothing
        run_slot(1'b0, 1'b0);
        // Directed: contention, single, empty
        run_slot(1'b1, 1'b1);
        run_slot(1'b1, 1'b0);
        run_slot(1'b0, 1'b0);
        // R5: contention twice discards the first stored packet
        run_slot(1'b1, 1'b1);
        run_slot(1'b1, 1'b1);
        run_slot(1'b0, 1'b1);
        run_slot(1'b0, 1'b0);
        run_slot(1'b0, 1'b0);
        // Every three-slot combination
        for (int a = 0; a < 4; a++)
            for (int b = 0; b < 4; b++)
                for (int c = 0; c < 4; c++) begin
                    run_slot(a[0], a[1]);
                    run_slot(b[0], b[1]);
                    run_slot(c[0], c[1]);
                end
        for (int k = 0; k < 300; k++) begin
            int r = $urandom_range(0, 3);
            run_slot(r[0], r[1]);
        end
        // R1: reset mid-stream empties the store
        run_slot(1'b1, 1'b1);
        rst = 1'b1;
        @(posedge clk);
        #1;
        rst = 1'b0;
        check("R1 valid after reset", int'(out_valid), 0);
        ref_full = 1'b0;
        run_slot(1'b0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule